// File: doc/BRIEF.md
# I2C Short-Transaction Sequencer

This block runs a whole short I2C transaction in hardware, so software does not handle each byte. A transaction is a write of 1 to 8 bytes, a read of 1 to 8 bytes, or a write followed by a read. Software first loads the outgoing bytes into two 32-bit data windows. It then writes one control word that carries the target address, the phases to run, both lengths and how the two phases are joined. It then waits for the interrupt. After completion it reads the received bytes from two more 32-bit windows and checks an error flag.

The sequencer does not drive the bus wires. It hands START, byte-write, byte-read and STOP commands, one at a time, to a bit-level byte engine. A command is a single-cycle `engCmdValid` pulse. The engine answers with a single-cycle `engDone` pulse, which carries the acknowledge bit it saw on a write, or the byte it received on a read. Completion sets a cause bit, and a mask bit gates that cause onto `irq`.

Top module: `i2c_seq_top`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0 and no engine command is issued.
- R2: The register word index selects the register. The indices are 0 control, 1 TX low, 2 TX high, 3 RX low, 4 RX high, 5 status, 6 cause and 7 mask. A control write launches a transaction when the block is idle, bit 19 is 1 and at least one phase bit is set. In the control word, bit 0 enables the write phase, bit 1 enables the read phase, bits [11:2] hold the address, bit 12 selects 10-bit addressing, bits [15:13] hold the TX length minus 1, bits [18:16] hold the RX length minus 1 and bit 20 selects a repeated START between phases.
- R3: A write phase issues START, then the address byte `{addr[6:0],0}`, then TX bytes 0 up to length−1, then STOP. Byte 0 is taken from TX low bits [7:0], and bytes 4 to 7 come from TX high.
- R4: A read phase sends `{addr[6:0],1}` and then reads length bytes. It acknowledges each byte except the last, which it NACKs before STOP. Received byte i lands in RX bits [8i+7:8i] (the low word first). Bytes that were not received read 0.
- R5: With both phases enabled, the write phase runs first. If bit 20 is 1, the read phase follows after a repeated START. If bit 20 is 0, it follows after STOP and then START.
- R6: With 10-bit addressing, the write phase sends `{11110,a[9:8],0}` and then `a[7:0]`. A read phase that directly follows a write phase through a repeated START sends only `{11110,a[9:8],1}`. Any other read phase sends `{11110,a[9:8],0}`, then `a[7:0]`, then a repeated START, then `{11110,a[9:8],1}`.
- R7: A NACK on any address byte or write byte stops all further bytes. The block then issues STOP, sets status bit 0 and sets the cause bit. A new launch clears status bit 0.
- R8: Completion sets cause bit 0. Writing the cause register with bit 0 = 0 clears it, and writing it with bit 0 = 1 leaves it unchanged. `irq` equals cause AND mask bit 0.
- R9: Status bit 1 reads 1 while a transaction runs. Control writes made during that time are ignored.
- R10: A control write with bit 19 = 0, or with both phase bits 0, starts nothing: busy stays 0 and no command is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word index |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data of the register at `regAddr` (combinational) |
| engCmdValid | output | 1 | Single-cycle command pulse to the byte engine |
| engCmdOp | output | 2 | 0 START, 1 write byte, 2 read byte, 3 STOP |
| engCmdData | output | 8 | Byte to transmit (0 for other commands) |
| engCmdNack | output | 1 | On a read command: NACK the byte instead of acknowledging it |
| engDone | input | 1 | Engine has finished the outstanding command |
| engNackIn | input | 1 | With `engDone` after a write: the target did not acknowledge |
| engRxByte | input | 8 | With `engDone` after a read: the received byte |
| irq | output | 1 | Completion interrupt |

## Verification
The engine model checks every command against a sequence the bench derives from the control word. This is done for 7-bit writes of 3 and 8 bytes, reads of 1 and 8 bytes, and write-then-read in both joining modes. The 1-byte read shows that the last-byte NACK is applied to byte 0. The two joining modes differ only by the extra STOP. The 10-bit cases (write, read only, write plus read) distinguish the three address preambles. NACKs injected on the address byte and on a middle data byte show that the abort cuts the sequence at the right point and raises the error flag. Engine latencies of 0 and several cycles show that sequencing waits on `engDone` rather than on fixed timing.

// File: rtl/i2c_seq_pkg.sv
`timescale 1ns/1ps
package i2c_seq_pkg;
  localparam int LEN_W   = 3;
  localparam int NBYTES  = 1 << LEN_W;
  localparam int BYTE_W  = 8;
  localparam int BUF_W   = NBYTES * BYTE_W;
  localparam int REG_W   = 32;
  localparam int RA_W    = 3;
  localparam int ADDR_W  = 10;
  localparam int CW_W    = 21;

  // control word bit positions (software-visible)
  localparam int CB_WR   = 0;
  localparam int CB_RD   = 1;
  localparam int CB_ADDR = 2;
  localparam int CB_TEN  = 12;
  localparam int CB_TXL  = 13;
  localparam int CB_RXL  = 16;
  localparam int CB_EN   = 19;
  localparam int CB_RS   = 20;

  // register word indices
  localparam logic [RA_W-1:0] RA_CTRL  = 3'd0;
  localparam logic [RA_W-1:0] RA_TXLO  = 3'd1;
  localparam logic [RA_W-1:0] RA_TXHI  = 3'd2;
  localparam logic [RA_W-1:0] RA_RXLO  = 3'd3;
  localparam logic [RA_W-1:0] RA_RXHI  = 3'd4;
  localparam logic [RA_W-1:0] RA_STAT  = 3'd5;
  localparam logic [RA_W-1:0] RA_CAUSE = 3'd6;
  localparam logic [RA_W-1:0] RA_MASK  = 3'd7;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } engOp_t;

  typedef struct packed {
    logic              wrEn;
    logic              rdEn;
    logic              ten;
    logic              rs;
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  txLast;
    logic [LEN_W-1:0]  rxLast;
  } seqCfg_t;

  typedef struct packed {
    logic             rxStore;
    logic [LEN_W-1:0] rxIdx;
    logic             setErr;
    logic             done;
  } seqStrobe_t;
endpackage

// File: rtl/i2c_seq_dp.sv
`timescale 1ns/1ps
module i2c_seq_dp
  import i2c_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [RA_W-1:0]    regAddr,
  input  logic [REG_W-1:0]   regWrData,
  output logic [REG_W-1:0]   regRdData,
  input  logic               busy,
  input  seqStrobe_t         strobe,
  input  logic [LEN_W-1:0]   txIdx,
  input  logic [BYTE_W-1:0]  engRxByte,
  output logic               startReq,
  output seqCfg_t            cfg,
  output logic [CW_W-1:0]    ctrlWord,
  output logic [BYTE_W-1:0]  txByte,
  output logic               causeBit,
  output logic               irq
);
  logic [BUF_W-1:0] txBuf;
  logic [BUF_W-1:0] rxBuf;
  logic             errBit;
  logic             maskBit;
  logic             ctrlWrite;

  assign ctrlWrite = regWe && (regAddr == RA_CTRL) && !busy;
  assign startReq  = ctrlWrite && regWrData[CB_EN] &&
                     (regWrData[CB_WR] || regWrData[CB_RD]);

  // control word decode
  always_comb begin
    cfg.wrEn   = ctrlWord[CB_WR];
    cfg.rdEn   = ctrlWord[CB_RD];
    cfg.ten    = ctrlWord[CB_TEN];
    cfg.rs     = ctrlWord[CB_RS];
    cfg.addr   = ctrlWord[CB_ADDR +: ADDR_W];
    cfg.txLast = ctrlWord[CB_TXL +: LEN_W];
    cfg.rxLast = ctrlWord[CB_RXL +: LEN_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlWord <= '0;
      txBuf    <= '0;
      maskBit  <= 1'b0;
      causeBit <= 1'b0;
      errBit   <= 1'b0;
    end else begin
      if (ctrlWrite) ctrlWord <= regWrData[CW_W-1:0];
      if (regWe && regAddr == RA_TXLO) txBuf[REG_W-1:0] <= regWrData;
      if (regWe && regAddr == RA_TXHI) txBuf[BUF_W-1:REG_W] <= regWrData;
      if (regWe && regAddr == RA_MASK) maskBit <= regWrData[0];
      if (strobe.done) causeBit <= 1'b1;
      else if (regWe && regAddr == RA_CAUSE && !regWrData[0]) causeBit <= 1'b0;
      if (startReq) errBit <= 1'b0;
      else if (strobe.setErr) errBit <= 1'b1;
    end
  end

  // one receive lane per byte position
  for (genvar b = 0; b < NBYTES; b++) begin : g_rxLane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) rxBuf[b*BYTE_W +: BYTE_W] <= '0;
      else if (startReq) rxBuf[b*BYTE_W +: BYTE_W] <= '0;
      else if (strobe.rxStore && strobe.rxIdx == LEN_W'(b))
        rxBuf[b*BYTE_W +: BYTE_W] <= engRxByte;
    end
  end

  assign txByte = txBuf[txIdx*BYTE_W +: BYTE_W];
  assign irq    = causeBit & maskBit;

  always_comb begin
    regRdData = '0;
    case (regAddr)
      RA_CTRL:  regRdData = {{(REG_W-CW_W){1'b0}}, ctrlWord};
      RA_TXLO:  regRdData = txBuf[REG_W-1:0];
      RA_TXHI:  regRdData = txBuf[BUF_W-1:REG_W];
      RA_RXLO:  regRdData = rxBuf[REG_W-1:0];
      RA_RXHI:  regRdData = rxBuf[BUF_W-1:REG_W];
      RA_STAT:  regRdData = {{(REG_W-2){1'b0}}, busy, errBit};
      RA_CAUSE: regRdData = {{(REG_W-1){1'b0}}, causeBit};
      default:  regRdData = {{(REG_W-1){1'b0}}, maskBit};
    endcase
  end
endmodule

// File: rtl/i2c_seq_ctl.sv
`timescale 1ns/1ps
module i2c_seq_ctl
  import i2c_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  seqCfg_t           cfg,
  input  logic              engDone,
  input  logic              engNackIn,
  input  logic [BYTE_W-1:0] txByte,
  output logic              busy,
  output logic              cmdValid,
  output engOp_t            cmdOp,
  output logic [BYTE_W-1:0] cmdData,
  output logic              cmdNack,
  output logic [LEN_W-1:0]  txIdx,
  output seqStrobe_t        strobe
);
  typedef enum logic [2:0] {
    S_IDLE, S_START, S_ADDR, S_WR, S_RD, S_STOP
  } seqState_t;

  seqState_t        state;
  logic             issued;
  logic             phaseRd;
  logic             moreAfterStop;
  logic [1:0]       step;
  logic [LEN_W-1:0] idx;

  logic             rdPhase;
  logic             fin;
  logic             addrNack;
  logic [1:0]       firstStep;
  logic [4:0]       hdrHi;
  logic [BYTE_W-1:0] addrByte;

  assign rdPhase   = phaseRd | ~cfg.wrEn;
  assign fin       = issued && engDone;
  assign hdrHi     = 5'b11110;
  assign firstStep = cfg.ten ? ((rdPhase && cfg.wrEn && cfg.rs) ? 2'd3 : 2'd0) : 2'd3;
  assign addrNack  = engNackIn && (step != 2'd2);

  always_comb begin
    case (step)
      2'd0:    addrByte = {hdrHi, cfg.addr[9:8], 1'b0};
      2'd1:    addrByte = cfg.addr[7:0];
      2'd2:    addrByte = '0;
      default: addrByte = cfg.ten ? {hdrHi, cfg.addr[9:8], 1'b1}
                                  : {cfg.addr[6:0], rdPhase};
    endcase
  end

  always_comb begin
    cmdOp   = OP_START;
    cmdData = '0;
    cmdNack = 1'b0;
    case (state)
      S_ADDR: begin
        if (step == 2'd2) cmdOp = OP_START;
        else begin
          cmdOp   = OP_WRITE;
          cmdData = addrByte;
        end
      end
      S_WR: begin
        cmdOp   = OP_WRITE;
        cmdData = txByte;
      end
      S_RD: begin
        cmdOp   = OP_READ;
        cmdNack = (idx == cfg.rxLast);
      end
      S_STOP:  cmdOp = OP_STOP;
      default: cmdOp = OP_START;
    endcase
  end

  assign busy     = (state != S_IDLE);
  assign cmdValid = busy && !issued;
  assign txIdx    = idx;

  always_comb begin
    strobe.rxStore = fin && (state == S_RD);
    strobe.rxIdx   = idx;
    strobe.setErr  = fin && ((state == S_ADDR && addrNack) ||
                             (state == S_WR && engNackIn));
    strobe.done    = fin && (state == S_STOP) && !moreAfterStop;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state         <= S_IDLE;
      issued        <= 1'b0;
      phaseRd       <= 1'b0;
      moreAfterStop <= 1'b0;
      step          <= 2'd0;
      idx           <= '0;
    end else begin
      if (cmdValid) issued <= 1'b1;
      else if (fin) issued <= 1'b0;

      case (state)
        S_IDLE: begin
          if (startReq) begin
            state         <= S_START;
            phaseRd       <= 1'b0;
            moreAfterStop <= 1'b0;
          end
        end
        S_START: begin
          if (fin) begin
            state <= S_ADDR;
            step  <= firstStep;
          end
        end
        S_ADDR: begin
          if (fin) begin
            if (addrNack) state <= S_STOP;
            else begin
              case (step)
                2'd0: step <= 2'd1;
                2'd1: begin
                  if (rdPhase) step <= 2'd2;
                  else begin
                    state <= S_WR;
                    idx   <= '0;
                  end
                end
                2'd2: step <= 2'd3;
                default: begin
                  idx   <= '0;
                  state <= rdPhase ? S_RD : S_WR;
                end
              endcase
            end
          end
        end
        S_WR: begin
          if (fin) begin
            if (engNackIn) state <= S_STOP;
            else if (idx == cfg.txLast) begin
              if (cfg.rdEn) begin
                phaseRd <= 1'b1;
                if (cfg.rs) state <= S_START;
                else begin
                  moreAfterStop <= 1'b1;
                  state         <= S_STOP;
                end
              end else state <= S_STOP;
            end else idx <= idx + 1'b1;
          end
        end
        S_RD: begin
          if (fin) begin
            if (idx == cfg.rxLast) state <= S_STOP;
            else idx <= idx + 1'b1;
          end
        end
        S_STOP: begin
          if (fin) begin
            if (moreAfterStop) begin
              moreAfterStop <= 1'b0;
              state         <= S_START;
            end else state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_seq_top.sv
`timescale 1ns/1ps
module i2c_seq_top
  import i2c_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [RA_W-1:0]   regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              engCmdValid,
  output logic [1:0]        engCmdOp,
  output logic [BYTE_W-1:0] engCmdData,
  output logic              engCmdNack,
  input  logic              engDone,
  input  logic              engNackIn,
  input  logic [BYTE_W-1:0] engRxByte,
  output logic              irq
);
  logic              busy;
  logic              startReq;
  logic              causeBit;
  logic [CW_W-1:0]   ctrlWord;
  logic [BYTE_W-1:0] txByte;
  logic [LEN_W-1:0]  txIdx;
  seqCfg_t           cfg;
  seqStrobe_t        strobe;
  engOp_t            cmdOp;

  i2c_seq_dp u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .busy(busy),
    .strobe(strobe), .txIdx(txIdx), .engRxByte(engRxByte),
    .startReq(startReq), .cfg(cfg), .ctrlWord(ctrlWord),
    .txByte(txByte), .causeBit(causeBit), .irq(irq)
  );

  i2c_seq_ctl u_ctl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cfg(cfg),
    .engDone(engDone), .engNackIn(engNackIn), .txByte(txByte),
    .busy(busy), .cmdValid(engCmdValid), .cmdOp(cmdOp),
    .cmdData(engCmdData), .cmdNack(engCmdNack), .txIdx(txIdx),
    .strobe(strobe)
  );

  assign engCmdOp = cmdOp;
endmodule

// File: rtl/i2c_seq_chk.sv
`timescale 1ns/1ps
module i2c_seq_chk
  import i2c_seq_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            busy,
  input logic            cmdValid,
  input logic [CW_W-1:0] ctrlWord,
  input logic            causeBit,
  input logic            regWe,
  input logic [RA_W-1:0] regAddr,
  input logic            enBit
);
  // R1: nothing is sent to the engine while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !cmdValid);

  // R2: at most one command outstanding, never back-to-back pulses
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  // R8: the end of a transaction leaves the cause bit set
  a_r8_cause_on_end: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> causeBit);

  // R9: control word cannot change while running
  a_r9_ctrl_frozen: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(ctrlWord));

  // R10: a control write without the enable bit starts nothing
  a_r10_no_launch: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == RA_CTRL && !busy && !enBit) |=> !busy);
endmodule

bind i2c_seq_top i2c_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .cmdValid(engCmdValid),
  .ctrlWord(ctrlWord), .causeBit(causeBit), .regWe(regWe),
  .regAddr(regAddr), .enBit(regWrData[19])
);

// File: tb/i2c_seq_top_tb.sv
`timescale 1ns/1ps
module i2c_seq_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWrData = 32'd0;
  logic [31:0] regRdData;
  logic        engCmdValid;
  logic [1:0]  engCmdOp;
  logic [7:0]  engCmdData;
  logic        engCmdNack;
  logic        engDone = 1'b0;
  logic        engNackIn = 1'b0;
  logic [7:0]  engRxByte = 8'd0;
  logic        irq;

  i2c_seq_top u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .engCmdValid(engCmdValid), .engCmdOp(engCmdOp),
    .engCmdData(engCmdData), .engCmdNack(engCmdNack),
    .engDone(engDone), .engNackIn(engNackIn), .engRxByte(engRxByte),
    .irq(irq)
  );

  always #2.5 clk = ~clk;

  int nChk = 0;
  int nFail = 0;
  int expQ[$];
  string curReq = "R1";

  // engine model state
  int  lat = 0;
  int  nackAt = -1;
  int  rxBase = 0;
  int  wrCnt = 0;
  int  rdCnt = 0;
  bit  pend = 0;
  int  cnt = 0;
  bit  respNack = 0;
  logic [7:0] respRx = 8'd0;

  // builder scratch
  int  bWc = 0;
  bit  bAb = 0;
  bit  expErr = 0;
  logic [63:0] rxExp = 64'd0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int enc(input int op, input int nk, input int d);
    return (op << 9) | (nk << 8) | (d & 255);
  endfunction

  task automatic pw(input int d);
    if (!bAb) begin
      expQ.push_back(enc(1, 0, d));
      if (bWc == nackAt) begin
        expQ.push_back(enc(3, 0, 0));
        bAb = 1;
      end
      bWc++;
    end
  endtask

  task automatic pushOp(input int op);
    if (!bAb) expQ.push_back(enc(op, 0, 0));
  endtask

  // expected command list derived from the control word
  task automatic build(input logic [20:0] c, input logic [63:0] tx);
    bit wr, rd, ten, rs;
    logic [9:0] a;
    int tl, rl, hdr;
    wr = c[0]; rd = c[1]; ten = c[12]; rs = c[20]; a = c[11:2];
    tl = int'(c[15:13]) + 1; rl = int'(c[18:16]) + 1;
    hdr = 8'hF0 | (int'(a[9:8]) << 1);
    expQ.delete(); bWc = 0; bAb = 0; rxExp = 64'd0;
    pushOp(0);
    if (wr) begin
      if (ten) begin pw(hdr); pw(int'(a[7:0])); end
      else pw(int'(a[6:0]) << 1);
      for (int i = 0; i < tl; i++) pw(int'(tx[i*8 +: 8]));
      if (rd) begin
        if (!rs) pushOp(3);
        pushOp(0);
      end
    end
    if (rd) begin
      if (ten) begin
        if (!(wr && rs)) begin pw(hdr); pw(int'(a[7:0])); pushOp(0); end
        pw(hdr | 1);
      end else pw((int'(a[6:0]) << 1) | 1);
      for (int i = 0; i < rl; i++) begin
        if (!bAb) begin
          expQ.push_back(enc(2, (i == rl - 1) ? 1 : 0, 0));
          rxExp[i*8 +: 8] = 8'(rxBase + i);
        end
      end
    end
    pushOp(3);
    expErr = bAb;
  endtask

  // byte engine model and per-command comparison
  initial begin
    forever begin
      @(negedge clk);
      engDone = 1'b0;
      engNackIn = 1'b0;
      if (pend) begin
        if (cnt == 0) begin
          engDone = 1'b1;
          engNackIn = respNack;
          engRxByte = respRx;
          pend = 0;
        end else cnt--;
      end
      if (rstN && engCmdValid) begin
        int got;
        got = enc(int'(engCmdOp), int'(engCmdNack),
                  (engCmdOp == 2'd1) ? int'(engCmdData) : 0);
        if (expQ.size() == 0)
          chk(0, curReq, "unexpected engine command", got, 0);
        else begin
          int e;
          e = expQ.pop_front();
          chk(got == e, curReq, "engine command", got, e);
        end
        respNack = 0;
        if (engCmdOp == 2'd1) begin
          respNack = (wrCnt == nackAt);
          wrCnt++;
        end
        if (engCmdOp == 2'd2) begin
          respRx = 8'(rxBase + rdCnt);
          rdCnt++;
        end
        pend = 1;
        cnt = lat;
      end
    end
  end

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  function automatic logic [31:0] mkCtrl(input bit wr, input bit rd, input int a,
      input bit ten, input int tl, input int rl, input bit rs);
    logic [31:0] w;
    w = 32'd0;
    w[0] = wr; w[1] = rd; w[11:2] = 10'(a); w[12] = ten;
    w[15:13] = 3'(tl - 1); w[18:16] = 3'(rl - 1); w[19] = 1'b1; w[20] = rs;
    return w;
  endfunction

  task automatic startTxn(input string req, input logic [31:0] c,
      input logic [63:0] tx, input int nk, input int l, input int rb);
    curReq = req; nackAt = nk; lat = l; rxBase = rb; wrCnt = 0; rdCnt = 0;
    build(c[20:0], tx);
    regWrite(3'd1, tx[31:0]);
    regWrite(3'd2, tx[63:32]);
    regWrite(3'd0, c);
  endtask

  task automatic finishTxn(input string req, input bit rd, input bit clr);
    logic [31:0] v;
    int n;
    n = 0;
    do begin regRead(3'd5, v); n++; end while (v[1] && n < 5000);
    chk(!v[1], req, "busy cleared", v[1], 0);
    chk(expQ.size() == 0, req, "commands left", expQ.size(), 0);
    chk(v[0] == expErr, req, "error bit", v[0], expErr);
    regRead(3'd6, v);
    chk(v[0] == 1'b1, req, "cause set", v, 1);
    if (rd && !expErr) begin
      regRead(3'd3, v);
      chk(v == rxExp[31:0], req, "rx low", v, rxExp[31:0]);
      regRead(3'd4, v);
      chk(v == rxExp[63:32], req, "rx high", v, rxExp[63:32]);
    end
    if (clr) begin
      regWrite(3'd6, 32'd0);
      regWrite(3'd0, 32'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++; nChk++;
    $display("FAIL %s watchdog: actual timeout expected completion", curReq);
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] c;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    for (int r = 0; r < 8; r++) begin
      regRead(3'(r), v);
      chk(v == 32'd0, "R1", "register after reset", v, 0);
    end
    chk(irq == 1'b0 && engCmdValid == 1'b0, "R1", "irq/cmd after reset",
        {irq, engCmdValid}, 0);

    // R2 R3: 7-bit write, 3 bytes, zero latency
    startTxn("R3", mkCtrl(1, 0, 7'h52, 0, 3, 1, 0), 64'h0000_0000_0033_2211, -1, 0, 0);
    finishTxn("R2", 0, 1);
    // R3: 8-byte write, slow engine
    startTxn("R3", mkCtrl(1, 0, 7'h2D, 0, 8, 1, 0), 64'h8877_6655_4433_2211, -1, 3, 0);
    finishTxn("R3", 0, 1);
    // R4: single-byte read, NACK on byte 0
    startTxn("R4", mkCtrl(0, 1, 7'h11, 0, 1, 1, 0), 64'd0, -1, 1, 8'hA5);
    finishTxn("R4", 1, 1);
    // R4: 8-byte read
    startTxn("R4", mkCtrl(0, 1, 7'h6E, 0, 1, 8, 0), 64'd0, -1, 2, 8'h40);
    finishTxn("R4", 1, 1);
    // R5: write then read with repeated START
    startTxn("R5", mkCtrl(1, 1, 7'h3C, 0, 2, 3, 1), 64'h0000_0000_0000_BEEF, -1, 0, 8'h10);
    finishTxn("R5", 1, 1);
    // R5: write then read with STOP+START
    startTxn("R5", mkCtrl(1, 1, 7'h3C, 0, 1, 2, 0), 64'h0000_0000_0000_0077, -1, 1, 8'h20);
    finishTxn("R5", 1, 1);
    // R6: 10-bit write, read only, write+read repeated START
    startTxn("R6", mkCtrl(1, 0, 10'h2A5, 1, 2, 1, 0), 64'h0000_0000_0000_CAFE, -1, 0, 0);
    finishTxn("R6", 0, 1);
    startTxn("R6", mkCtrl(0, 1, 10'h1C3, 1, 1, 2, 0), 64'd0, -1, 1, 8'h70);
    finishTxn("R6", 1, 1);
    startTxn("R6", mkCtrl(1, 1, 10'h3FF, 1, 1, 1, 1), 64'h0000_0000_0000_0055, -1, 0, 8'h90);
    finishTxn("R6", 1, 1);
    // R7: NACK on the address byte, then on the second data byte
    startTxn("R7", mkCtrl(1, 1, 7'h01, 0, 4, 2, 1), 64'h0000_0000_4433_2211, 0, 0, 0);
    finishTxn("R7", 1, 1);
    startTxn("R7", mkCtrl(1, 0, 7'h01, 0, 4, 1, 0), 64'h0000_0000_4433_2211, 2, 2, 0);
    finishTxn("R7", 0, 1);
    // R7: next launch clears the error bit
    startTxn("R7", mkCtrl(1, 0, 7'h05, 0, 1, 1, 0), 64'h0000_0000_0000_0009, -1, 0, 0);
    finishTxn("R7", 0, 1);

    // R8: cause, mask and irq
    regWrite(3'd7, 32'd1);
    startTxn("R8", mkCtrl(0, 1, 7'h22, 0, 1, 1, 0), 64'd0, -1, 0, 8'h01);
    finishTxn("R8", 1, 0);
    chk(irq == 1'b1, "R8", "irq with cause and mask", irq, 1);
    regWrite(3'd6, 32'd1);
    chk(irq == 1'b1, "R8", "cause write of 1 keeps it", irq, 1);
    regWrite(3'd7, 32'd0);
    chk(irq == 1'b0, "R8", "irq masked", irq, 0);
    regWrite(3'd7, 32'd1);
    chk(irq == 1'b1, "R8", "irq unmasked", irq, 1);
    regWrite(3'd6, 32'd0);
    chk(irq == 1'b0, "R8", "irq after cause clear", irq, 0);
    regRead(3'd6, v);
    chk(v == 32'd0, "R8", "cause readback cleared", v, 0);
    regWrite(3'd0, 32'd0);
    regWrite(3'd7, 32'd0);

    // R9: control writes ignored while busy
    c = mkCtrl(0, 1, 7'h4B, 0, 1, 8, 0);
    startTxn("R9", c, 64'd0, -1, 20, 8'hC0);
    regRead(3'd5, v);
    chk(v[1] == 1'b1, "R9", "busy flag while running", v[1], 1);
    regWrite(3'd0, mkCtrl(1, 0, 7'h01, 0, 1, 1, 0));
    regRead(3'd0, v);
    chk(v == c, "R9", "control word while busy", v, c);
    finishTxn("R9", 1, 1);

    // R10: writes that must not launch
    curReq = "R10"; expQ.delete();
    c = mkCtrl(1, 0, 7'h12, 0, 1, 1, 0);
    c[19] = 1'b0;
    regWrite(3'd0, c);
    repeat (20) @(negedge clk);
    regRead(3'd5, v);
    chk(v[1] == 1'b0, "R10", "busy without enable bit", v[1], 0);
    c = mkCtrl(0, 0, 7'h12, 0, 1, 1, 0);
    regWrite(3'd0, c);
    repeat (20) @(negedge clk);
    regRead(3'd5, v);
    chk(v[1] == 1'b0, "R10", "busy without phase bits", v[1], 0);
    regRead(3'd6, v);
    chk(v[0] == 1'b0, "R10", "cause untouched", v[0], 0);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule